// File: doc/BRIEF.md
# SDRAM Read/Write Command Sequencer

This block sits between a simple single-word access port and the command bus of a four-bank synchronous DRAM. Each accepted request (read or write, bank, row, column, write data, byte masks and an auto-close flag) is turned into the command cycles the memory needs. If the addressed bank is closed, the row is opened. If a different row is open, that row is closed first. Then the column access is sent, with or without auto precharge. A row-state tracker per bank remembers which row is open and holds the counters that enforce the activate-to-access, close-to-open, open-to-close and write-recovery spacings. All spacings are cycle counts set through parameters.

The request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from acceptance until the column access for that request has been issued, so the producer holds its request until it sees ready. Read data returns on `rsp_valid`/`rsp_data` as a single-cycle pulse. The memory cannot be stalled, so this port has no ready and the consumer must take every beat.

The read-capture delay follows `cas3`, which selects a CAS latency of 3 (high) or 2 (low). `cas3` must be held steady while reads are in flight. Refresh and initialization belong to an outside agent. It raises `maint_req`. The sequencer closes every open bank, waits out the close time and lets in-flight read data drain. It then raises `maint_grant` and keeps the bus at NOP until `maint_req` falls.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `req_ready` is high, and `rsp_valid` and `maint_grant` are low.
- R2: A request to a closed bank first issues ACTIVE (4'b0011) with the row on the address pins and the bank on `sd_ba`. READ (4'b0101) or WRITE (4'b0100) is never issued to a closed bank.
- R3: A request that hits the open row of its bank issues only the column access, with no ACTIVE and no PRECHARGE.
- R4: A request for a different row than the one open in its bank issues PRECHARGE (4'b0010) with address bit 10 low for that bank only, then ACTIVE, then the access.
- R5: On READ and WRITE the column is on address bits 7..0, bit 10 carries the auto-precharge flag, and bits 8, 9 and 11 are zero. On WRITE, `sd_dq_oe` is high, `sd_dq_out` carries the data and `sd_dqm` carries the mask (bit 0 = lower byte, bit 1 = upper byte, 1 = byte not written). `sd_dq_oe` is low in every other cycle.
- R6: After an access with auto precharge, the bank counts as closed, so the next request to it issues ACTIVE again and no PRECHARGE.
- R7: Command spacing per bank in cycles: ACTIVE to READ/WRITE at least T_RCD; PRECHARGE (or auto-precharge close) to ACTIVE at least T_RP; ACTIVE to PRECHARGE or auto-precharge access at least T_RAS; WRITE to PRECHARGE at least T_WR. An auto-precharged write adds T_WR before the close time starts.
- R8: A READ on the pins in cycle k has `sd_dq_in` sampled at the end of cycle k+CL, and that word appears on `rsp_data` with `rsp_valid` high in cycle k+CL+1. CL is 3 when `cas3` is high and 2 otherwise.
- R9: When `maint_req` is raised, one PRECHARGE with address bit 10 high closes all banks if any bank is open (none is sent otherwise). After that `maint_grant` rises, the pins stay NOP while it is high, and all banks are closed afterwards.
- R10: `req_ready` is low while a request is in progress and while maintenance is pending or granted. Request fields are captured at acceptance, so changing them afterwards has no effect.
- R11: Every cycle without a command carries NOP, and only the five command codes above ever appear.
- R12: No WRITE is issued while read data is still due on the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank |
| req_row | input | 12 | Row |
| req_col | input | 8 | Column |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte masks, 1 = skip byte |
| req_autopre | input | 1 | Close the row with the access |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 16 | Read data |
| cas3 | input | 1 | CAS latency 3 when high, 2 when low |
| maint_req | input | 1 | Outside agent asks for an idle, closed bus |
| maint_grant | output | 1 | Bus idle and all banks closed |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Drive enable for data bus |
| sd_dq_in | input | 16 | Read data from memory |

## Verification
The hardest case to reach is a write that directly follows a read. Here the write must wait until the read word has come back, and under CAS latency 3 that wait is a cycle longer. The bench issues a row-hit read immediately followed by a row-hit write, under both latencies, and its memory model flags any write that lands while read data is still due. A second hard case is a maintenance request that arrives while a freshly opened bank has not yet met its open-to-close time. The bench opens a bank and raises the request at once, so the all-bank close has to wait on that counter. The model then checks the spacing on every command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sdcmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WORK,
    S_MPRE,
    S_MWAIT,
    S_MGNT
  } seq_state_e;
endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 4,
  parameter int T_RP  = 2,
  parameter int T_RAS = 5,
  parameter int T_WR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_pre,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             can_act,
  output logic             can_pre
);
  logic [CNT_W-1:0] ras_q, wr_q, rp_q;
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      ras_q  <= '0;
      wr_q   <= '0;
      rp_q   <= '0;
    end else begin
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (wr_q  != '0) wr_q  <= wr_q - 1'b1;
      if (rp_q  != '0) rp_q  <= rp_q - 1'b1;
      if (do_act) begin
        open_q <= 1'b1;
        row_q  <= row_in;
        ras_q  <= CNT_W'(T_RAS - 1);
      end
      if (do_wr) wr_q <= CNT_W'(T_WR - 1);
      if ((do_rd || do_wr) && ap) begin
        open_q <= 1'b0;
        rp_q   <= do_wr ? CNT_W'(T_WR + T_RP - 1) : CNT_W'(T_RP - 1);
      end
      if (do_pre) begin
        open_q <= 1'b0;
        if (rp_q < CNT_W'(T_RP)) rp_q <= CNT_W'(T_RP - 1);
      end
    end
  end

  assign open_o  = open_q;
  assign row_o   = row_q;
  assign can_act = !open_q && (rp_q == '0);
  assign can_pre = (ras_q == '0) && (wr_q == '0);

  assert_access_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd || do_wr) |-> open_q);
  assert_act_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!open_q && rp_q == '0));
  assert_close_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pre && open_q) |-> (ras_q == '0 && wr_q == '0));
  assert_ap_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((do_rd || do_wr) && ap) |-> (ras_q == '0));
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DW     = 16,
  parameter int MAX_CL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_rd,
  input  logic          cas3,
  input  logic [DW-1:0] dq_in,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [MAX_CL:0] pipe_q;
  logic            tap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      pipe_q    <= {pipe_q[MAX_CL-1:0], issue_rd};
      rsp_valid <= tap;
      if (tap) rsp_data <= dq_in;
    end
  end

  assign tap  = cas3 ? pipe_q[3] : pipe_q[2];
  assign busy = |pipe_q;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DW     = 16,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 5,
  parameter int T_WR   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DW-1:0]    req_wdata,
  input  logic [1:0]       req_mask,
  input  logic             req_autopre,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  input  logic             cas3,
  input  logic             maint_req,
  output logic             maint_grant,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [1:0]       sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic [1:0]       sd_dqm,
  output logic [DW-1:0]    sd_dq_out,
  output logic             sd_dq_oe,
  input  logic [DW-1:0]    sd_dq_in
);
  localparam int BA_W  = $clog2(BANKS);
  localparam int CNT_W = $clog2(T_RCD + T_RP + T_RAS + T_WR + 1);

  seq_state_e       state_q, state_d;
  sdcmd_e           cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d, r_bank;
  logic [ROW_W-1:0] addr_q, addr_d, r_row;
  logic [COL_W-1:0] r_col;
  logic [DW-1:0]    dq_q, dq_d, r_data;
  logic [1:0]       dqm_q, dqm_d, r_mask;
  logic             oe_q, oe_d, r_write, r_ap, take;
  logic [CNT_W-1:0] rcd_q;
  logic             iss_act, iss_rd, iss_wr, iss_pre, pre_all, rd_busy;
  logic [BANKS-1:0] open_v, can_act_v, can_pre_v;
  logic [ROW_W-1:0] row_v [BANKS];

  assign req_ready   = (state_q == S_IDLE) && !maint_req;
  assign maint_grant = (state_q == S_MGNT);

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    ba_d    = r_bank;
    addr_d  = '0;
    dq_d    = '0;
    dqm_d   = '0;
    oe_d    = 1'b0;
    take    = 1'b0;
    iss_act = 1'b0;
    iss_rd  = 1'b0;
    iss_wr  = 1'b0;
    iss_pre = 1'b0;
    pre_all = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (maint_req) state_d = S_MPRE;
        else if (req_valid) begin
          take    = 1'b1;
          state_d = S_WORK;
        end
      end
      S_WORK: begin
        if (open_v[r_bank] && row_v[r_bank] == r_row) begin
          if (rcd_q == '0 && (!r_ap || can_pre_v[r_bank]) && (!r_write || !rd_busy)) begin
            iss_rd  = !r_write;
            iss_wr  = r_write;
            cmd_d   = r_write ? CMD_WR : CMD_RD;
            addr_d[COL_W-1:0] = r_col;
            addr_d[AP_BIT]    = r_ap;
            dq_d    = r_write ? r_data : '0;
            dqm_d   = r_write ? r_mask : 2'b00;
            oe_d    = r_write;
            state_d = S_IDLE;
          end
        end else if (open_v[r_bank]) begin
          if (can_pre_v[r_bank]) begin
            iss_pre = 1'b1;
            cmd_d   = CMD_PRE;
          end
        end else if (can_act_v[r_bank]) begin
          iss_act = 1'b1;
          cmd_d   = CMD_ACT;
          addr_d  = r_row;
        end
      end
      S_MPRE: begin
        if (open_v == '0) state_d = S_MWAIT;
        else if (&can_pre_v) begin
          pre_all        = 1'b1;
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          state_d        = S_MWAIT;
        end
      end
      S_MWAIT: if (&can_act_v && !rd_busy) state_d = S_MGNT;
      S_MGNT:  if (!maint_req) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      dq_q    <= '0;
      dqm_q   <= '0;
      oe_q    <= 1'b0;
      rcd_q   <= '0;
      r_write <= 1'b0;
      r_bank  <= '0;
      r_row   <= '0;
      r_col   <= '0;
      r_data  <= '0;
      r_mask  <= '0;
      r_ap    <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      dq_q    <= dq_d;
      dqm_q   <= dqm_d;
      oe_q    <= oe_d;
      if (iss_act) rcd_q <= CNT_W'(T_RCD - 1);
      else if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (take) begin
        r_write <= req_write;
        r_bank  <= req_bank;
        r_row   <= req_row;
        r_col   <= req_col;
        r_data  <= req_wdata;
        r_mask  <= req_mask;
        r_ap    <= req_autopre;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (r_bank == BA_W'(b));
    sdram_bank_track #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR)
    ) i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_act  (iss_act && sel),
      .do_rd   (iss_rd && sel),
      .do_wr   (iss_wr && sel),
      .do_pre  ((iss_pre && sel) || pre_all),
      .ap      (r_ap),
      .row_in  (r_row),
      .open_o  (open_v[b]),
      .row_o   (row_v[b]),
      .can_act (can_act_v[b]),
      .can_pre (can_pre_v[b])
    );
  end

  sdram_rd_capture #(.DW(DW), .MAX_CL(3)) i_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_rd  (iss_rd),
    .cas3      (cas3),
    .dq_in     (sd_dq_in),
    .busy      (rd_busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;

  assert_grant_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    maint_grant |-> (open_v == '0));
  assert_grant_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    maint_grant |-> (cmd_q == CMD_NOP));
  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && maint_grant));
  assert_no_wr_in_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR) |-> !rsp_valid);
  assert_cl2_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_q == CMD_RD, 3) && !$past(cas3, 3)) |-> rsp_valid);
  assert_cl3_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_q == CMD_RD, 4) && $past(cas3, 4)) |-> rsp_valid);
  assert_oe_only_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd_q == CMD_WR));
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_RP = 2, T_RAS = 5, T_WR = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_write = 0, req_autopre = 0;
  logic [1:0] req_bank = 0, req_mask = 0;
  logic [11:0] req_row = 0;
  logic [7:0] req_col = 0;
  logic [15:0] req_wdata = 0, rsp_data, sd_dq_out;
  logic [15:0] sd_dq_in = 16'hBAD0;
  logic rsp_valid, cas3 = 0, maint_req = 0, maint_grant;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR)) i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_mask(req_mask), .req_autopre(req_autopre),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cas3(cas3), .maint_req(maint_req),
    .maint_grant(maint_grant), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int n_checks = 0, n_fail = 0, cyc = 0, cl = 2;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Memory model and protocol monitor
  bit m_open[4];
  int m_row[4], last_act[4], last_pre[4], last_wr[4];
  int last_rd_data = -1000;
  int n_act = 0, n_pre = 0, n_pre_all = 0, n_acc = 0;
  logic [15:0] mem[int], slot[int];
  int exp_arr[$];
  logic [15:0] exp_dat[$];
  logic [3:0] cmdv;
  int k, b, key, ea;
  logic [15:0] d, e;

  initial for (int i = 0; i < 4; i++) begin
    last_act[i] = -1000; last_pre[i] = -1000; last_wr[i] = -1000; m_open[i] = 0;
  end

  always @(negedge clk) if (rst_n) begin
    k = cyc;
    cmdv = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = int'(sd_ba);
    if (slot.exists(k)) begin sd_dq_in = slot[k]; slot.delete(k); end
    else sd_dq_in = 16'hBAD0;
    if (sd_dq_oe && cmdv != C_WR) chk(0, "R5 oe outside write", 1, 0);
    case (cmdv)
      C_NOP: ;
      C_ACT: begin
        n_act++;
        chk(!m_open[b], "R2 ACTIVE to closed bank", m_open[b], 0);
        chk(k - last_pre[b] >= T_RP, "R7 close to ACTIVE", k - last_pre[b], T_RP);
        m_open[b] = 1; m_row[b] = int'(sd_addr); last_act[b] = k;
      end
      C_RD, C_WR: begin
        n_acc++;
        chk(m_open[b], "R2 access to open bank", m_open[b], 1);
        chk(k - last_act[b] >= T_RCD, "R7 ACTIVE to access", k - last_act[b], T_RCD);
        chk(sd_addr[9:8] == 0 && !sd_addr[11], "R5 unused address bits", sd_addr, 0);
        key = b * 1048576 + m_row[b] * 256 + int'(sd_addr[7:0]);
        if (cmdv == C_WR) begin
          chk(sd_dq_oe, "R5 oe on write", sd_dq_oe, 1);
          chk(k > last_rd_data, "R12 write while read due", k, last_rd_data + 1);
          d = mem.exists(key) ? mem[key] : 16'h0;
          if (!sd_dqm[0]) d[7:0] = sd_dq_out[7:0];
          if (!sd_dqm[1]) d[15:8] = sd_dq_out[15:8];
          mem[key] = d; last_wr[b] = k;
        end else begin
          d = mem.exists(key) ? mem[key] : 16'h0;
          slot[k + cl] = d; last_rd_data = k + cl; exp_arr.push_back(k + cl + 1);
        end
        if (sd_addr[10]) begin
          chk(k - last_act[b] >= T_RAS, "R7 ACTIVE to auto close", k - last_act[b], T_RAS);
          m_open[b] = 0; last_pre[b] = k + ((cmdv == C_WR) ? T_WR : 0);
        end
      end
      C_PRE: begin
        if (sd_addr[10]) n_pre_all++; else n_pre++;
        for (int i = 0; i < 4; i++) if (sd_addr[10] || i == b) begin
          if (m_open[i]) begin
            chk(k - last_act[i] >= T_RAS, "R7 ACTIVE to PRECHARGE", k - last_act[i], T_RAS);
            chk(k - last_wr[i] >= T_WR, "R7 WRITE to PRECHARGE", k - last_wr[i], T_WR);
          end
          m_open[i] = 0;
          if (last_pre[i] < k) last_pre[i] = k;
        end
      end
      default: chk(0, "R11 unknown command", cmdv, C_NOP);
    endcase
    if (maint_grant) begin
      if (cmdv != C_NOP) chk(0, "R9 command during grant", cmdv, C_NOP);
      if (req_ready) chk(0, "R10 ready during grant", 1, 0);
    end
    if (rsp_valid) begin
      if (exp_arr.size() == 0) chk(0, "R8 unexpected response", 1, 0);
      else begin
        ea = exp_arr.pop_front();
        chk(k == ea, "R8 response cycle", k, ea);
        e = (exp_dat.size() != 0) ? exp_dat.pop_front() : 16'hxxxx;
        chk(rsp_data == e, "R8 response data", rsp_data, e);
      end
    end
  end

  // Bench reference (from the requirements)
  logic [15:0] ref_mem[int];
  bit ref_open[4];
  int ref_row[4];

  task automatic do_req(bit wr, int bk, int row, int col, logic [15:0] dat,
                        logic [1:0] msk, bit ap, string tag);
    int a0, p0, c0, xa, xp, rk;
    logic [15:0] v;
    rk = bk * 1048576 + row * 256 + col;
    if (ref_open[bk] && ref_row[bk] == row) begin xa = 0; xp = 0; end
    else if (ref_open[bk]) begin xa = 1; xp = 1; end
    else begin xa = 1; xp = 0; end
    ref_open[bk] = !ap; ref_row[bk] = row;
    v = ref_mem.exists(rk) ? ref_mem[rk] : 16'h0;
    if (wr) begin
      if (!msk[0]) v[7:0] = dat[7:0];
      if (!msk[1]) v[15:8] = dat[15:8];
      ref_mem[rk] = v;
    end else exp_dat.push_back(v);
    a0 = n_act; p0 = n_pre; c0 = n_acc;
    @(negedge clk);
    req_write = wr; req_bank = 2'(bk); req_row = 12'(row); req_col = 8'(col);
    req_wdata = dat; req_mask = msk; req_autopre = ap; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = !wr; req_bank = ~req_bank; req_row = ~req_row;
    req_col = ~req_col; req_wdata = ~dat; req_mask = ~msk; req_autopre = !ap;
    chk(!req_ready, "R10 ready low while busy", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk); #1;
    chk(n_act - a0 == xa, {tag, " ACTIVE count"}, n_act - a0, xa);
    chk(n_pre - p0 == xp, {tag, " PRECHARGE count"}, n_pre - p0, xp);
    chk(n_acc - c0 == 1, {tag, " access count"}, n_acc - c0, 1);
  endtask

  task automatic do_maint(int xpa, bit open_first);
    int p0;
    p0 = n_pre_all;
    @(negedge clk);
    maint_req = 1;
    @(negedge clk);
    chk(!req_ready, "R10 ready low when maintenance pending", req_ready, 0);
    while (!maint_grant) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
    chk(n_pre_all - p0 == xpa, "R9 close-all count", n_pre_all - p0, xpa);
    chk(!(m_open[0] | m_open[1] | m_open[2] | m_open[3]), "R9 banks closed", open_first, 0);
    maint_req = 0;
    for (int i = 0; i < 4; i++) ref_open[i] = 0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_dat.size() != 0 && n < 50) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 NOP after reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(!rsp_valid && !maint_grant, "R1 no response or grant", {rsp_valid, maint_grant}, 0);

    do_req(1, 0, 5, 3, 16'hA1B2, 2'b00, 0, "R2 closed bank write");
    do_req(0, 0, 5, 3, 16'h0, 2'b00, 0, "R3 row hit read");
    do_req(1, 0, 5, 4, 16'hFFFF, 2'b01, 0, "R5 masked lower byte");
    do_req(0, 0, 5, 4, 16'h0, 2'b00, 0, "R3 row hit read masked");
    do_req(0, 0, 9, 3, 16'h0, 2'b00, 0, "R4 row miss read");
    do_req(1, 1, 2, 10, 16'h1234, 2'b10, 1, "R6 auto close write");
    do_req(0, 1, 2, 10, 16'h0, 2'b00, 0, "R6 reopen after auto close");
    do_req(0, 0, 9, 3, 16'h0, 2'b00, 0, "R12 read before write");
    do_req(1, 0, 9, 7, 16'h5A5A, 2'b00, 0, "R12 write after read CL2");
    drain();
    @(negedge clk); cas3 = 1; cl = 3;
    do_req(0, 0, 9, 7, 16'h0, 2'b00, 0, "R8 CL3 read");
    do_req(1, 0, 9, 8, 16'hC3C3, 2'b00, 0, "R12 write after read CL3");
    do_req(0, 0, 9, 8, 16'h0, 2'b00, 1, "R6 auto close read");
    do_req(0, 2, 7, 1, 16'h0, 2'b00, 0, "R2 open bank two");
    do_maint(1, 1);
    do_maint(0, 0);
    do_req(0, 2, 7, 1, 16'h0, 2'b00, 0, "R9 reopen after maintenance");
    drain();
    do_req(1, 3, 4, 2, 16'h7777, 2'b00, 0, "R2 open bank three");
    do_maint(1, 1);
    drain();
    @(negedge clk); cas3 = 0; cl = 2;
    s = 32'h1ACE;
    for (int i = 0; i < 48; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7FFFFFFF;
      do_req((s >> 10) & 1, (s >> 3) & 3, (s >> 6) % 3, (s >> 12) & 3,
             16'((s >> 8) ^ i), 2'((s >> 14) & 3), ((s >> 17) & 7) == 0, "R7 mixed traffic");
    end
    drain();
    chk(exp_dat.size() == 0, "R8 all responses returned", exp_dat.size(), 0);
    summary();
  end
endmodule